// File: doc/BRIEF.md
# Protected Two-Level Pin Function Multiplexer

This block holds the configuration of a large array of I/O pins behind a simple 32-bit register bus. There are two register banks with the same layout. The first bank holds, for each pin, a function field plus pull and drive-strength controls. The second bank holds an extended function number for each pin. That number is used only when the first-level field holds the escape code. The second bank also has two small selector registers. Each one routes a management-data channel to high impedance or to one of seven internal sources.

Each bank has a protect register that guards its contents against stray writes. The key is the protect register's own full bus address. Writing the key locks the bank, and writing the key with bit 0 set unlocks it. Software unlocks a bank, writes its configuration words, then locks the bank again. For every pin the block drives a registered resolved function index, a normalised pull mode and a drive code, which pad logic and peripheral routing use.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset every configuration word and both selector registers are zero, and both banks are locked. Each protect register reads 1, and every pin outputs function 0, pull 0 and drive 0.
- R2: The key of a bank is BUS_BASE + bank offset + 0x400, where the bank offset is 0x0000 for the first bank and 0x1000 for the second. Writing the key to the bank's protect register locks the bank. Writing key+1 unlocks it. Any other value leaves the lock state unchanged. The protect register reads the lock state in bit 0 (1 = locked) and zero in all other bits.
- R3: While a bank is locked, writes to its configuration words and selector registers are ignored.
- R4: First-level word n is at byte offset 4*n. Its function field is bits 3:0, its pull field bits 9:8 and its drive field bits 11:10. Second-level word n is at 0x1000 + 4*n and keeps bits 5:0. Unstored bits read as zero. A read returns the stored bits on bus_rdata one cycle after the read is presented.
- R5: A first-level function of 0 to 9 gives that index. A first-level function of 15 gives 10 plus the second-level value (0 to 61), which yields indices 10 to 71.
- R6: A first-level function of 10 to 14 gives the invalid index 127. An escaped second-level value of 62 or 63 also gives 127.
- R7: The pull output is 00 for none, 01 for up and 11 for down. A stored pull code 2 is output as 00 but still reads back as 2.
- R8: The drive output equals the stored 2-bit drive code. Codes 0 to 3 stand for 4, 6, 8 and 12 mA.
- R9: The selector registers are at 0x1404 (channel 0) and 0x1408 (channel 1). Each keeps bits 2:0, where 0 means high impedance and 1 to 7 select a source. The value appears on mgmt0_src or mgmt1_src from the clock edge of the write onward.
- R10: Reads of unmapped or misaligned offsets return zero, and writes to them change nothing. This covers words at or above the pin count and offsets 0x404 and 0x408 of the first bank.
- R11: Pin outputs change on the second clock edge after a configuration write: one edge to store the word and one to register the output.
- R12: Writing the configuration of one pin leaves the outputs of every other pin unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_fn | output | NUM_PINS*7 | Resolved function index per pin |
| pin_pull | output | NUM_PINS*2 | Normalised pull mode per pin |
| pin_drive | output | NUM_PINS*2 | Drive code per pin |
| mgmt0_src | output | 3 | Management-data channel 0 source select |
| mgmt1_src | output | 3 | Management-data channel 1 source select |

## Verification
The hardest situations to reach are those where the lock decides the outcome of a write. These are a configuration or selector write while the bank is locked, and a protect write with a near-miss key such as the other bank's key. To reach them, the stimulus mixes unlock, lock and wrong-key writes with writes to the first bank, the second bank and the selectors. It then reads the protect state and the stored words back, and compares them with the pin outputs. The escape path is driven into its invalid corners by pairing code 15 with second-level values 61, 62 and 63. The bench also checks pin outputs on the cycle between storage and output registration.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int FN_W      = 7;
  localparam int L1_W      = 8;
  localparam int L2_W      = 6;
  localparam int SRC_W     = 3;
  localparam logic [3:0] FN_ESCAPE  = 4'hF;
  localparam logic [3:0] DIRECT_MAX = 4'd9;
  localparam logic [5:0] EXT_MAX    = 6'd61;
  localparam logic [6:0] EXT_BASE   = 7'd10;
  localparam logic [6:0] FN_INVALID = 7'h7F;

  typedef struct packed {
    logic [1:0] drive;
    logic [1:0] pull;
    logic [3:0] fn;
  } l1_cfg_t;

  function automatic logic [FN_W-1:0] resolve_fn(input logic [3:0] l1fn,
                                                 input logic [L2_W-1:0] ext);
    logic [FN_W-1:0] r;
    if (l1fn <= DIRECT_MAX)      r = {3'b000, l1fn};
    else if (l1fn == FN_ESCAPE)  r = (ext <= EXT_MAX) ? ({1'b0, ext} + EXT_BASE) : FN_INVALID;
    else                         r = FN_INVALID;
    return r;
  endfunction

  function automatic logic [1:0] norm_pull(input logic [1:0] code);
    return (code == 2'b10) ? 2'b00 : code;
  endfunction

  function automatic logic [31:0] l1_to_word(input l1_cfg_t c);
    return {20'h0, c.drive, c.pull, 4'h0, c.fn};
  endfunction

  function automatic l1_cfg_t word_to_l1(input logic [31:0] w);
    l1_cfg_t c;
    c.drive = w[11:10];
    c.pull  = w[9:8];
    c.fn    = w[3:0];
    return c;
  endfunction
endpackage

// File: rtl/pmx_guard.sv
module pmx_guard #(
  parameter logic [31:0] KEY = 32'h0000_0400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        prot_wr,
  input  logic [31:0] wdata,
  output logic        locked
);
  localparam logic [31:0] KEY_OPEN = KEY | 32'h1;

  always_ff @(posedge clk) begin
    if (rst)                               locked <= 1'b1;
    else if (prot_wr && wdata == KEY)      locked <= 1'b1;
    else if (prot_wr && wdata == KEY_OPEN) locked <= 1'b0;
  end

  AST_KEY_LOCKS: assert property (@(posedge clk) disable iff (rst)
    (prot_wr && wdata == KEY) |=> locked);                                        // R2
  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
    (prot_wr && wdata == KEY_OPEN) |=> !locked);                                  // R2
  AST_BAD_KEY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(prot_wr && (wdata == KEY || wdata == KEY_OPEN))) |=> $stable(locked));     // R2
endmodule

// File: rtl/pmx_cfg_bank.sv
module pmx_cfg_bank #(
  parameter int NUM_PINS = 170,
  parameter int W        = 8,
  localparam int PIN_W   = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  locked,
  input  logic                  wr_en,
  input  logic [PIN_W-1:0]      wr_idx,
  input  logic [W-1:0]          wr_data,
  input  logic [PIN_W-1:0]      rd_idx,
  output logic [W-1:0]          rd_data,
  output logic [NUM_PINS*W-1:0] flat
);
  logic [W-1:0] mem [NUM_PINS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PINS; i++) mem[i] <= '0;
    end else if (wr_en && !locked && wr_idx < PIN_W'(NUM_PINS)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_idx < PIN_W'(NUM_PINS)) rd_data = mem[rd_idx];
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_flat
    assign flat[g*W +: W] = mem[g];
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(flat));                                                    // R3
endmodule

// File: rtl/pmx_pin_resolve.sv
module pmx_pin_resolve
  import pmx_pkg::*;
#(
  parameter int NUM_PINS = 170
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_PINS*L1_W-1:0] l1_flat,
  input  logic [NUM_PINS*L2_W-1:0] l2_flat,
  output logic [NUM_PINS*FN_W-1:0] pin_fn,
  output logic [NUM_PINS*2-1:0]    pin_pull,
  output logic [NUM_PINS*2-1:0]    pin_drive
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    l1_cfg_t         cfg;
    logic [L2_W-1:0] ext;
    assign cfg = l1_cfg_t'(l1_flat[g*L1_W +: L1_W]);
    assign ext = l2_flat[g*L2_W +: L2_W];

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_fn[g*FN_W +: FN_W] <= '0;
        pin_pull[g*2 +: 2]     <= '0;
        pin_drive[g*2 +: 2]    <= '0;
      end else begin
        pin_fn[g*FN_W +: FN_W] <= resolve_fn(cfg.fn, ext);
        pin_pull[g*2 +: 2]     <= norm_pull(cfg.pull);
        pin_drive[g*2 +: 2]    <= cfg.drive;
      end
    end

    AST_FN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (pin_fn[g*FN_W +: FN_W] <= 7'd71 || pin_fn[g*FN_W +: FN_W] == FN_INVALID)); // R6
    AST_PULL_CODE: assert property (@(posedge clk) disable iff (rst)
      pin_pull[g*2 +: 2] != 2'b10);                                               // R7
  end
endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pmx_pkg::*;
#(
  parameter int          NUM_PINS = 170,
  parameter int          ADDR_W   = 13,
  parameter logic [31:0] BUS_BASE = 32'h4006_0000,
  parameter logic [31:0] PROT_OFF = 32'h0000_0400
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic [NUM_PINS*FN_W-1:0] pin_fn,
  output logic [NUM_PINS*2-1:0]    pin_pull,
  output logic [NUM_PINS*2-1:0]    pin_drive,
  output logic [SRC_W-1:0]         mgmt0_src,
  output logic [SRC_W-1:0]         mgmt1_src
);
  localparam int          BANK_BIT  = ADDR_W - 1;
  localparam int          WIDX_W    = ADDR_W - 3;
  localparam int          PIN_W     = $clog2(NUM_PINS);
  localparam int          PROT_WIDX = int'(PROT_OFF >> 2);
  localparam logic [31:0] KEY_L1    = BUS_BASE + PROT_OFF;
  localparam logic [31:0] KEY_L2    = BUS_BASE + (32'd1 << BANK_BIT) + PROT_OFF;

  logic              bank_hi, aligned, wr, rd;
  logic [WIDX_W-1:0] widx;
  logic [PIN_W-1:0]  pin_idx;
  logic              conf_hit, prot_hit, m0_hit, m1_hit;
  logic              lock_l1, lock_l2;
  logic [L1_W-1:0]   l1_rd;
  logic [L2_W-1:0]   l2_rd;
  logic [NUM_PINS*L1_W-1:0] l1_flat;
  logic [NUM_PINS*L2_W-1:0] l2_flat;
  logic [31:0]       rd_word;
  logic              any_hit;

  assign bank_hi  = bus_addr[BANK_BIT];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign widx     = bus_addr[BANK_BIT-1:2];
  assign pin_idx  = widx[PIN_W-1:0];
  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign conf_hit = aligned && (widx < WIDX_W'(NUM_PINS));
  assign prot_hit = aligned && (widx == WIDX_W'(PROT_WIDX));
  assign m0_hit   = aligned && bank_hi && (widx == WIDX_W'(PROT_WIDX + 1));
  assign m1_hit   = aligned && bank_hi && (widx == WIDX_W'(PROT_WIDX + 2));
  assign any_hit  = conf_hit || prot_hit || m0_hit || m1_hit;

  pmx_guard #(.KEY(KEY_L1)) u_guard_l1 (
    .clk(clk), .rst(rst), .prot_wr(wr && prot_hit && !bank_hi),
    .wdata(bus_wdata), .locked(lock_l1)
  );

  pmx_guard #(.KEY(KEY_L2)) u_guard_l2 (
    .clk(clk), .rst(rst), .prot_wr(wr && prot_hit && bank_hi),
    .wdata(bus_wdata), .locked(lock_l2)
  );

  pmx_cfg_bank #(.NUM_PINS(NUM_PINS), .W(L1_W)) u_bank_l1 (
    .clk(clk), .rst(rst), .locked(lock_l1),
    .wr_en(wr && conf_hit && !bank_hi), .wr_idx(pin_idx),
    .wr_data(word_to_l1(bus_wdata)), .rd_idx(pin_idx),
    .rd_data(l1_rd), .flat(l1_flat)
  );

  pmx_cfg_bank #(.NUM_PINS(NUM_PINS), .W(L2_W)) u_bank_l2 (
    .clk(clk), .rst(rst), .locked(lock_l2),
    .wr_en(wr && conf_hit && bank_hi), .wr_idx(pin_idx),
    .wr_data(bus_wdata[L2_W-1:0]), .rd_idx(pin_idx),
    .rd_data(l2_rd), .flat(l2_flat)
  );

  pmx_pin_resolve #(.NUM_PINS(NUM_PINS)) u_resolve (
    .clk(clk), .rst(rst), .l1_flat(l1_flat), .l2_flat(l2_flat),
    .pin_fn(pin_fn), .pin_pull(pin_pull), .pin_drive(pin_drive)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mgmt0_src <= '0;
      mgmt1_src <= '0;
    end else if (wr && !lock_l2) begin
      if (m0_hit) mgmt0_src <= bus_wdata[SRC_W-1:0];
      if (m1_hit) mgmt1_src <= bus_wdata[SRC_W-1:0];
    end
  end

  always_comb begin
    rd_word = '0;
    if (conf_hit && !bank_hi)     rd_word = l1_to_word(l1_cfg_t'(l1_rd));
    else if (conf_hit && bank_hi) rd_word = {{(32-L2_W){1'b0}}, l2_rd};
    else if (prot_hit)            rd_word = {31'h0, bank_hi ? lock_l2 : lock_l1};
    else if (m0_hit)              rd_word = {{(32-SRC_W){1'b0}}, mgmt0_src};
    else if (m1_hit)              rd_word = {{(32-SRC_W){1'b0}}, mgmt1_src};
  end

  always_ff @(posedge clk) begin
    if (rst)     bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_word;
  end

  AST_MGMT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    lock_l2 |=> ($stable(mgmt0_src) && $stable(mgmt1_src)));                      // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd && !any_hit) |=> (bus_rdata == 32'h0));                                   // R10
endmodule

// File: tb/sim_pinmux_ctrl.sv
module sim_pinmux_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 170;
  localparam logic [31:0] BASE = 32'h4006_0000;
  localparam logic [12:0] PROT1 = 13'h0400, PROT2 = 13'h1400, MUX0 = 13'h1404, MUX1 = 13'h1408;
  localparam logic [31:0] KEY1 = BASE + 32'h400, KEY2 = BASE + 32'h1400;

  logic        clk = 0, rst = 1, bus_sel = 0, bus_we = 0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP*7-1:0] pin_fn;
  logic [NP*2-1:0] pin_pull, pin_drive;
  logic [2:0]  mgmt0_src, mgmt1_src;
  int checks = 0, fails = 0, cycles = 0;

  pinmux_ctrl u0 (.clk, .rst, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
                  .pin_fn, .pin_pull, .pin_drive, .mgmt0_src, .mgmt1_src);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  function automatic logic [6:0] exp_fn(logic [3:0] f, logic [5:0] e);
    if (f < 10) return {3'b0, f};
    if (f == 15) return (e < 62) ? 7'(e) + 7'd10 : 7'd127;
    return 7'd127;
  endfunction

  function automatic logic [6:0] fn_of(int p);  return pin_fn[p*7 +: 7];   endfunction
  function automatic logic [1:0] pl_of(int p);  return pin_pull[p*2 +: 2]; endfunction
  function automatic logic [1:0] dr_of(int p);  return pin_drive[p*2 +: 2]; endfunction

  task automatic t_reset();
    logic [31:0] d;
    logic bad = 0;
    for (int p = 0; p < NP; p++)
      if (fn_of(p) != 0 || pl_of(p) != 0 || dr_of(p) != 0) bad = 1;
    check("R1 all pin outputs zero", 32'(bad), 0);
    rd(PROT1, d); check("R1 bank1 locked", d, 1);
    rd(PROT2, d); check("R1 bank2 locked", d, 1);
    rd(13'h0014, d); check("R1 conf word zero", d, 0);
    check("R1 mgmt zero", {26'h0, mgmt1_src, mgmt0_src}, 0);
  endtask

  task automatic t_locked_ignored();
    logic [31:0] d;
    wr(13'h0014, 32'h0000_0A03);
    wr(13'h101C, 32'd5);
    wr(MUX0, 32'd4);
    @(negedge clk);
    rd(13'h0014, d); check("R3 locked l1 write ignored", d, 0);
    rd(13'h101C, d); check("R3 locked l2 write ignored", d, 0);
    check("R3 locked pin output unchanged", 32'(fn_of(5)), 0);
    check("R3 locked mux write ignored", 32'(mgmt0_src), 0);
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(PROT1, 32'h1234_5679); rd(PROT1, d); check("R2 bad value keeps lock", d, 1);
    wr(PROT1, KEY2 | 1);      rd(PROT1, d); check("R2 other bank key keeps lock", d, 1);
    wr(PROT1, KEY1 | 1);      rd(PROT1, d); check("R2 key+1 unlocks", d, 0);
    wr(PROT1, 32'h0);         rd(PROT1, d); check("R2 bad value keeps unlock", d, 0);
    wr(PROT2, KEY2 | 1);      rd(PROT2, d); check("R2 bank2 unlock", d, 0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr(13'h0014, 32'h0000_0903);
    check("R11 output not yet updated", 32'(fn_of(5)), 0);
    @(negedge clk);
    check("R5 direct fn 3", 32'(fn_of(5)), 3);
    check("R7 pull up", 32'(pl_of(5)), 1);
    check("R8 drive code 2", 32'(dr_of(5)), 2);
    check("R12 neighbour pin unchanged", {fn_of(6), pl_of(6), dr_of(6)}, 0);
    wr(13'h0018, 32'hFFFF_FFFF);
    rd(13'h0018, d); check("R4 unstored bits read zero", d, 32'h0000_0F0F);
    check("R7 pull down", 32'(pl_of(6)), 3);
    check("R5 escape with l2=0", 32'(fn_of(6)), 32'(exp_fn(4'hF, 6'd0)));
    wr(13'h0018, 32'h0000_0209);
    @(negedge clk);
    check("R7 pull code 2 is none", 32'(pl_of(6)), 0);
    check("R5 direct fn 9", 32'(fn_of(6)), 9);
    rd(13'h0018, d); check("R7 pull 2 reads back", d, 32'h0000_0209);
    wr(13'h0018, 32'h0000_000C);
    @(negedge clk);
    check("R6 l1 code 12 invalid", 32'(fn_of(6)), 127);
  endtask

  task automatic t_escape();
    logic [31:0] d;
    wr(13'h10A4, 32'hFFFF_FFBD);
    rd(13'h10A4, d); check("R4 l2 keeps 6 bits", d, 32'd61);
    wr(13'h00A4, 32'h0000_0C0F);
    @(negedge clk);
    check("R5 escape to 71", 32'(fn_of(41)), 71);
    check("R8 drive code 3", 32'(dr_of(41)), 3);
    wr(13'h10A4, 32'd62); @(negedge clk);
    check("R6 l2 value 62 invalid", 32'(fn_of(41)), 127);
    wr(13'h10A4, 32'd63); @(negedge clk);
    check("R6 l2 value 63 invalid", 32'(fn_of(41)), 127);
    wr(13'h12A4, 32'd20);
    wr(13'h02A4, 32'h0000_000F); @(negedge clk);
    check("R5 last pin escape", 32'(fn_of(169)), 30);
  endtask

  task automatic t_mux();
    logic [31:0] d;
    wr(MUX0, 32'hFFFF_FFF5);
    check("R9 channel0 source", 32'(mgmt0_src), 5);
    wr(MUX1, 32'd7);
    rd(MUX1, d); check("R9 channel1 readback", d, 7);
    wr(PROT2, KEY2);
    rd(PROT2, d); check("R2 bank2 relocked", d, 1);
    wr(MUX1, 32'd2);
    check("R3 mux ignored after relock", 32'(mgmt1_src), 7);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(13'h0320, 32'hFFFF_FFFF);
    rd(13'h0320, d); check("R10 word above pin count", d, 0);
    rd(13'h0404, d); check("R10 bank1 0x404", d, 0);
    rd(13'h0015, d); check("R10 misaligned", d, 0);
    wr(13'h0019, 32'h0000_0001);
    rd(13'h0018, d); check("R10 misaligned write ignored", d, 32'h0000_000C);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_locked_ignored();
    t_keys();
    t_direct();
    t_escape();
    t_mux();
    t_unmapped();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule